// File: doc/BRIEF.md
# Shared-Bus Addressable Configuration Port

This block is the device side of a three-wire serial configuration port: an active-low select, a serial clock and a data line. The data line is split at the pad into an input, an output and an output enable. A host uses the port to write and read a small register file that configures the rest of the chip. Up to four copies of the chip can sit on one bus with no separate select lines. Each copy reads two strap inputs that give it its own device number.

After reset the port is in broadcast mode. Every well-formed write is committed whatever device number it carries, so all chips on the bus receive the same setup. Writing the software-control bit of the interface control register switches the port to addressed mode. From then on, only frames whose device number equals the straps are acted on. The same control register can move read data to a separate data-out pin, which turns the port into a four-wire interface. It also supplies the enable and mode functions, replacing the pins, and can request a soft reset. A read-only status word holds the lock flag, the calibration-failed flag and the calibration code.

The serial lines are sampled by the chip clock through synchronizers, so the serial clock must be several times slower than the chip clock. The serial port has no back-pressure: the host owns the timing of every bit. Configuration outputs are plain levels.

Top module: `mdc_cfg_port`

## Requirements
- R1: After reset every register reads zero, the port is in broadcast mode, `sdio_oe` and `sdo` are low, and `enable_o`/`mode_o` follow their pins.
- R2: A frame is 26 bits, most significant bit first, sampled on rising `sclk` while `sel_n` is low: read flag (1 = read), 2-bit device number, 7-bit register index, then 16 data bits. A write commits when `sel_n` rises after exactly 26 bits.
- R3: In broadcast mode a write commits whatever device number the frame carries.
- R4: In addressed mode (control register index 0, bit 0 set) a write commits only if its device number equals `strap`.
- R5: A frame ended by `sel_n` rising after fewer or more than 26 clock edges leaves every register unchanged.
- R6: For an accepted read in three-wire mode, `sdio_oe` is high only from the 10th rising edge to the 26th. Register data appears on `sdio_out` with its most significant bit first, and the host samples it on rising edges 11 through 26.
- R7: A read whose device number does not match in addressed mode drives neither `sdio_oe` nor `sdo`.
- R8: With four-wire mode set (control bit 1), read data appears on `sdo` with the same timing as R6, and `sdio_oe` stays low.
- R9: Register index 127 returns the status word: lock in bit 15, calibration-failed in bit 14, the 7-bit calibration code in bits 6..0, and zeros elsewhere. Writes to it change nothing.
- R10: In addressed mode, `enable_o` and `mode_o` come from control bits 2 and 3 instead of the pins, and `gpo_o` carries bits 1..0 of register 1. In broadcast mode `gpo_o` is zero.
- R11: A committed write to register 0 with bit 4 set returns every register to zero, which restores broadcast mode.
- R12: Register indices from the register count (8) up to 126 are unused: writes to them change nothing and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdio_in | input | 1 | Shared data line, input side |
| sdio_out | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line, output enable |
| sdo | output | 1 | Separate read-data pin, used in four-wire mode |
| strap | input | 2 | Device number straps |
| en_pin | input | 1 | Enable pin, used in broadcast mode |
| mode_pin | input | 1 | Mode pin, used in broadcast mode |
| lock_i | input | 1 | Lock flag for the status word |
| cal_fail_i | input | 1 | Calibration-failed flag for the status word |
| cal_code_i | input | 7 | Calibration code for the status word |
| enable_o | output | 1 | Effective enable |
| mode_o | output | 1 | Effective mode |
| sw_mode_o | output | 1 | High in addressed (software-control) mode |
| gpo_o | output | 2 | General-purpose outputs |
| cfg_o | output | 128 | All register contents, register i in bits 16i+15..16i |

## Verification
The assertions check, on every cycle, that:
- the configuration changes only in the cycle after an accepted commit;
- addressed-mode commits always carry the strap number;
- broadcast writes are never filtered;
- the two read outputs are never both active;
- the pad is released once select goes away;
- the general-purpose outputs stay low in broadcast mode.

Only the bench's scenarios can show that bits arrive in the right order and that truncated or overlong frames are discarded. They also show that a mismatched read stays silent, that the status word and unused indices read back correctly, and that a soft reset returns the port to broadcast mode.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int DW         = 16;
  localparam int DEVW       = 2;
  localparam int REGW       = 7;
  localparam int HDR_BITS   = 1 + DEVW + REGW;
  localparam int FRAME_BITS = HDR_BITS + DW;

  // interface control register (index 0) bit positions
  localparam int CTL_SW   = 0;
  localparam int CTL_4W   = 1;
  localparam int CTL_EN   = 2;
  localparam int CTL_MODE = 3;
  localparam int CTL_SRST = 4;

  typedef struct packed {
    logic            rd;
    logic [DEVW-1:0] dev;
    logic [REGW-1:0] ra;
  } hdr_t;
endpackage

// File: rtl/mdc_sync.sv
module mdc_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[k] <= RST_VAL;
      else        st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mdc_frame_rx.sv
module mdc_frame_rx import mdc_pkg::*; #(
  parameter int CW = $clog2(FRAME_BITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_act,
  input  logic          sclk_rise,
  input  logic          sel_end,
  input  logic          sdi,
  output hdr_t          hdr,
  output logic          hdr_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      hdr     <= '0;
      hdr_stb <= 1'b0;
      wr_stb  <= 1'b0;
      wdata   <= '0;
    end else begin
      hdr_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (!sel_act) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sh <= {sh[DW-2:0], sdi};
        if (cnt != CW'(FRAME_BITS + 1)) cnt <= cnt + 1'b1;
        if (cnt == CW'(HDR_BITS - 1)) begin
          hdr     <= hdr_t'({sh[HDR_BITS-2:0], sdi});
          hdr_stb <= 1'b1;
        end
      end
      // commit only a complete write frame; short or long frames fall away
      if (sel_end && cnt == CW'(FRAME_BITS) && !hdr.rd) begin
        wr_stb <= 1'b1;
        wdata  <= sh;
      end
    end
  end
endmodule

// File: rtl/mdc_regfile.sv
module mdc_regfile import mdc_pkg::*; #(
  parameter int             NREGS   = 8,
  parameter logic [REGW-1:0] RB_ADDR = '1,
  parameter int             CALW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REGW-1:0]   wa,
  input  logic [DW-1:0]     wd,
  input  logic [REGW-1:0]   ra,
  output logic [DW-1:0]     rdata,
  input  logic              rb_lock,
  input  logic              rb_fail,
  input  logic [CALW-1:0]   rb_cal,
  output logic [NREGS*DW-1:0] regs_flat
);
  logic [DW-1:0] regs [NREGS];
  logic          srst;
  logic [DW-1:0] rb_word;

  assign srst    = we && (wa == '0) && wd[CTL_SRST];
  assign rb_word = {rb_lock, rb_fail, {(DW-2-CALW){1'b0}}, rb_cal};

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs[i] <= '0;
      else if (srst)                         regs[i] <= '0;
      else if (we && wa == REGW'(i))         regs[i] <= wd;
    end
    assign regs_flat[i*DW +: DW] = regs[i];
  end

  always_comb begin
    rdata = '0;
    if (ra == RB_ADDR) rdata = rb_word;
    for (int i = 0; i < NREGS; i++)
      if (ra == REGW'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/mdc_cfg_port.sv
module mdc_cfg_port import mdc_pkg::*; #(
  parameter int             NREGS   = 8,
  parameter logic [REGW-1:0] RB_ADDR = 7'h7F,
  parameter int             CALW    = 7,
  parameter int             GPOW    = 2,
  parameter int             SYNC_N  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                sclk,
  input  logic                sdio_in,
  output logic                sdio_out,
  output logic                sdio_oe,
  output logic                sdo,
  input  logic [DEVW-1:0]     strap,
  input  logic                en_pin,
  input  logic                mode_pin,
  input  logic                lock_i,
  input  logic                cal_fail_i,
  input  logic [CALW-1:0]     cal_code_i,
  output logic                enable_o,
  output logic                mode_o,
  output logic                sw_mode_o,
  output logic [GPOW-1:0]     gpo_o,
  output logic [NREGS*DW-1:0] cfg_o
);
  localparam int CW = $clog2(FRAME_BITS + 2);

  logic [2:0]    s_in;
  logic          s_sel, s_sclk, s_sdi;
  logic          sel_q, sclk_q;
  logic          sel_act, sclk_rise, sel_end;
  hdr_t          hdr;
  logic          hdr_stb, wr_stb, we, addr_ok;
  logic [DW-1:0] wdata, rdata, rd_sh, ctrl, gpo_reg;
  logic [CW-1:0] cnt;
  logic          rd_on;

  mdc_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdio_in}), .q(s_in));

  assign {s_sel, s_sclk, s_sdi} = s_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      sel_q  <= s_sel;
      sclk_q <= s_sclk;
    end
  end

  assign sel_act   = ~s_sel;
  assign sclk_rise = s_sclk & ~sclk_q;
  assign sel_end   = s_sel & ~sel_q;

  mdc_frame_rx #(.CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .sclk_rise(sclk_rise),
    .sel_end(sel_end), .sdi(s_sdi), .hdr(hdr), .hdr_stb(hdr_stb),
    .wr_stb(wr_stb), .wdata(wdata), .cnt(cnt));

  assign ctrl    = cfg_o[0 +: DW];
  assign gpo_reg = cfg_o[DW +: DW];
  assign addr_ok = !ctrl[CTL_SW] || (hdr.dev == strap);
  assign we      = wr_stb && addr_ok;

  mdc_regfile #(.NREGS(NREGS), .RB_ADDR(RB_ADDR), .CALW(CALW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .wa(hdr.ra), .wd(wdata),
    .ra(hdr.ra), .rdata(rdata), .rb_lock(lock_i), .rb_fail(cal_fail_i),
    .rb_cal(cal_code_i), .regs_flat(cfg_o));

  // read shifter: loaded after the header, advances on each later edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_on <= 1'b0;
      rd_sh <= '0;
    end else if (!sel_act) begin
      rd_on <= 1'b0;
    end else if (hdr_stb) begin
      rd_on <= hdr.rd && addr_ok;
      rd_sh <= rdata;
    end else if (sclk_rise && rd_on) begin
      rd_sh <= {rd_sh[DW-2:0], 1'b0};
      if (cnt == CW'(FRAME_BITS - 1)) rd_on <= 1'b0;
    end
  end

  assign sdio_out  = rd_sh[DW-1];
  assign sdio_oe   = rd_on && !ctrl[CTL_4W];
  assign sdo       = rd_on && ctrl[CTL_4W] && rd_sh[DW-1];
  assign sw_mode_o = ctrl[CTL_SW];
  assign enable_o  = ctrl[CTL_SW] ? ctrl[CTL_EN]   : en_pin;
  assign mode_o    = ctrl[CTL_SW] ? ctrl[CTL_MODE] : mode_pin;
  assign gpo_o     = ctrl[CTL_SW] ? gpo_reg[GPOW-1:0] : '0;
endmodule

// File: rtl/mdc_port_chk.sv
module mdc_port_chk import mdc_pkg::*; #(
  parameter int NREGS = 8,
  parameter int GPOW  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel_act,
  input logic                sdio_oe,
  input logic                sdo,
  input logic                four_w,
  input logic                sw,
  input logic                we,
  input logic                wr_stb,
  input logic [DEVW-1:0]     dev,
  input logic [DEVW-1:0]     strap,
  input logic [GPOW-1:0]     gpo_o,
  input logic [NREGS*DW-1:0] cfg_o
);
  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable(cfg_o)); // R5
  AST_ADDR_MATCHED: assert property (@(posedge clk) disable iff (!rst_n) (we && sw) |-> (dev == strap)); // R4
  AST_BCAST_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && !sw) |-> we); // R3
  AST_PAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !sel_act |=> !sdio_oe); // R6
  AST_ONE_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({sdio_oe, sdo})); // R8
  AST_SDO_NEEDS_4W: assert property (@(posedge clk) disable iff (!rst_n) sdo |-> four_w); // R8
  AST_GPO_IDLE_BCAST: assert property (@(posedge clk) disable iff (!rst_n) !sw |-> (gpo_o == '0)); // R10
endmodule

bind mdc_cfg_port mdc_port_chk #(.NREGS(NREGS), .GPOW(GPOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .sdio_oe(sdio_oe), .sdo(sdo),
  .four_w(ctrl[mdc_pkg::CTL_4W]), .sw(ctrl[mdc_pkg::CTL_SW]), .we(we),
  .wr_stb(wr_stb), .dev(hdr.dev), .strap(strap), .gpo_o(gpo_o), .cfg_o(cfg_o));

// File: tb/test_mdc_cfg_port.sv
module test_mdc_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 8;
  localparam int NREGS = 8;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sclk = 0, sdio_in = 0;
  logic sdio_out, sdio_oe, sdo;
  logic [1:0] strap = 2'd1;
  logic en_pin = 1, mode_pin = 1, lock_i = 0, cal_fail_i = 0;
  logic [6:0] cal_code_i = 0;
  logic enable_o, mode_o, sw_mode_o;
  logic [1:0] gpo_o;
  logic [NREGS*16-1:0] cfg_o, snap;

  int total = 0, bad = 0;
  int oe_hdr, oe_data, sdo_data;
  logic [15:0] got_word;
  logic [15:0] exp_q[$];
  string cur_req;
  event rd_done;

  mdc_cfg_port i_mdc_cfg_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .strap(strap),
    .en_pin(en_pin), .mode_pin(mode_pin), .lock_i(lock_i),
    .cal_fail_i(cal_fail_i), .cal_code_i(cal_code_i), .enable_o(enable_o),
    .mode_o(mode_o), .sw_mode_o(sw_mode_o), .gpo_o(gpo_o), .cfg_o(cfg_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_of(input int i);
    return cfg_o[i*16 +: 16];
  endfunction

  task automatic xfer(input logic rd, input logic [1:0] dev, input logic [6:0] ra,
                      input logic [15:0] wd, input int nbits, input logic fw);
    logic [25:0] f;
    f = {rd, dev, ra, wd};
    got_word = 0; oe_hdr = 0; oe_data = 0; sdo_data = 0;
    @(negedge clk) sel_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = (i < 26) ? f[25-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 10) begin
        if (sdio_oe) oe_hdr++;
      end else if (i < 26) begin
        if (sdio_oe) oe_data++;
        if (sdo) sdo_data++;
        got_word[25-i] = fw ? sdo : sdio_out;
      end
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    sel_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] dev, input logic [6:0] ra, input logic [15:0] wd, input int nbits);
    xfer(1'b0, dev, ra, wd, nbits, 1'b0);
  endtask

  task automatic rd(input string req, input logic [1:0] dev, input logic [6:0] ra,
                    input logic fw, input logic expect_drive, input logic [15:0] exp);
    cur_req = req;
    if (expect_drive) exp_q.push_back(exp);
    xfer(1'b1, dev, ra, 16'h0, 26, fw);
    if (expect_drive) begin
      -> rd_done;
      #1;
    end
    chk(req, "pad drive during header", oe_hdr, 0);
    if (!expect_drive || fw) chk(req, "pad drive in data phase", oe_data, 0);
    else                     chk(req, "pad drive in data phase", oe_data, 16);
    if (!expect_drive || !fw) chk(req, "sdo ones", sdo_data, 0);
  endtask

  // monitor: compares each finished read against the scoreboard queue
  initial forever begin
    @(rd_done);
    if (exp_q.size() == 0) chk(cur_req, "unexpected read", 1, 0);
    else chk(cur_req, "read word", got_word, exp_q.pop_front());
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "cfg after reset", cfg_o, 0);
    chk("R1", "pad oe", sdio_oe, 0);
    chk("R1", "sdo", sdo, 0);
    chk("R1", "sw mode", sw_mode_o, 0);
    chk("R1", "enable follows pin", enable_o, 1);
    // R2 / R3 broadcast writes, device numbers unrelated to straps
    wr(2'd3, 7'd2, 16'hA5A5, 26);
    chk("R2", "reg2 written", reg_of(2), 16'hA5A5);
    wr(2'd0, 7'd3, 16'h5A5A, 26);
    chk("R3", "broadcast reg3", reg_of(3), 16'h5A5A);
    // R5 short and long frames
    snap = cfg_o;
    wr(2'd1, 7'd2, 16'hFFFF, 20);
    chk("R5", "short frame dropped", cfg_o, snap);
    wr(2'd1, 7'd2, 16'hFFFF, 27);
    chk("R5", "long frame dropped", cfg_o, snap);
    // R6 three-wire read in broadcast
    rd("R6", 2'd2, 7'd2, 1'b0, 1'b1, 16'hA5A5);
    // R9 status word
    lock_i = 1; cal_fail_i = 0; cal_code_i = 7'h55;
    rd("R9", 2'd0, 7'h7F, 1'b0, 1'b1, 16'h8055);
    wr(2'd0, 7'h7F, 16'hFFFF, 26);
    chk("R9", "status write ignored", cfg_o, snap);
    lock_i = 0; cal_fail_i = 1; cal_code_i = 7'h7F;
    rd("R9", 2'd0, 7'h7F, 1'b0, 1'b1, 16'h407F);
    // R12 unused index
    wr(2'd1, 7'h10, 16'hBEEF, 26);
    chk("R12", "unused write ignored", cfg_o, snap);
    rd("R12", 2'd1, 7'h10, 1'b0, 1'b1, 16'h0000);
    // R10 soft control
    wr(2'd2, 7'd1, 16'h0003, 26);
    chk("R10", "gpo low in broadcast", gpo_o, 0);
    en_pin = 1; mode_pin = 1;
    wr(2'd2, 7'd0, 16'h0001, 26);
    chk("R10", "sw mode set", sw_mode_o, 1);
    chk("R10", "enable from ctrl", enable_o, 0);
    chk("R10", "mode from ctrl", mode_o, 0);
    chk("R10", "gpo from reg1", gpo_o, 2'b11);
    wr(2'd1, 7'd0, 16'h000D, 26);
    chk("R10", "enable bit", enable_o, 1);
    chk("R10", "mode bit", mode_o, 1);
    // R4 addressed writes
    wr(2'd2, 7'd2, 16'h1111, 26);
    chk("R4", "mismatch ignored", reg_of(2), 16'hA5A5);
    wr(2'd1, 7'd2, 16'h1111, 26);
    chk("R4", "match committed", reg_of(2), 16'h1111);
    // R7 mismatched read silent, matched read works
    rd("R7", 2'd0, 7'd2, 1'b0, 1'b0, 16'h0);
    rd("R6", 2'd1, 7'd2, 1'b0, 1'b1, 16'h1111);
    // R8 four-wire read
    wr(2'd1, 7'd0, 16'h000F, 26);
    rd("R8", 2'd1, 7'd2, 1'b1, 1'b1, 16'h1111);
    rd("R7", 2'd3, 7'd2, 1'b1, 1'b0, 16'h0);
    // R11 soft reset
    wr(2'd1, 7'd0, 16'h0010, 26);
    chk("R11", "all regs cleared", cfg_o, 0);
    chk("R11", "broadcast again", sw_mode_o, 0);
    en_pin = 0;
    @(negedge clk);
    chk("R11", "enable follows pin", enable_o, 0);
    wr(2'd3, 7'd3, 16'h00FF, 26);
    chk("R11", "broadcast write after soft reset", reg_of(3), 16'h00FF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule